// File: doc/BRIEF.md
# Scan Code to ASCII Translator

This block sits behind a PS/2 keyboard receiver. It takes the stream of received Scan Code Set 2 bytes, one byte per single-cycle strobe. It joins the extended prefix (0xE0) and the release prefix (0xF0) with the key byte that follows them, so that it sees each make or break sequence as one key event.

It keeps track of both shift keys, both control keys and the caps lock toggle. Each key press that has a character meaning is turned into a 7-bit ASCII value. That value is placed on a parallel bus, and a flag goes high to mark it as new. Releases, modifier keys and keys with no ASCII meaning put nothing on the bus.

A four-state sequencer does the work: it waits, absorbs a byte, translates, and then publishes. The source must leave at least four clock cycles between byte strobes.

Top module: `kbd_ascii_xlat`

## Requirements
- R1: After reset, `ascii_new` is 0 and `ascii_code` is 0.
- R2: When no modifier is active, a letter make produces the lowercase code; for example 0x1C gives 0x61. Counting the capture edge of the byte strobe as edge 1, `ascii_code` updates on edge 3 and `ascii_new` rises on edge 4.
- R3: `ascii_new` goes to 0 on the capture edge of every accepted byte, prefixes included. It stays 0 until a new code is published.
- R4: A release sequence produces no output and leaves `ascii_new` at 0. A release sequence is 0xF0 then the key byte, or 0xE0 0xF0 then the key byte.
- R5: While a shift key is held, letters come out in upper case, and digit and punctuation keys give their upper symbol. The shift keys are 0x12 and 0x59, each tracked through its own make and its own break. Examples: 0x16 gives '!' and 0x52 gives '"'.
- R6: Each make of 0x58 toggles caps lock. Caps lock inverts the letter case that shift selects, so caps plus shift gives lower case. It has no effect on digits or symbols.
- R7: While a control key is held, shift and caps lock are ignored. The control keys are 0x14 and 0xE0 0x14. A letter gives its uppercase code minus 0x40. If a key's plain character or shifted character lies in 0x40..0x5F, that value minus 0x40 is output: '[' gives 0x1B, '2' gives 0x00, '-' gives 0x1F. Any other character key produces no output while control is held.
- R8: Backspace (0x66), tab (0x0D), enter (0x5A), escape (0x76) and delete (0xE0 0x71) give 0x08, 0x09, 0x0D, 0x1B and 0x7F. Modifiers do not change these values.
- R9: Keys with no ASCII meaning produce no output and leave `ascii_new` at 0. This covers function keys such as 0x05, keypad keys such as 0x71 and 0xE0 0x5A, and the modifier keys.
- R10: The 0xE0 prefix changes which key a byte names: 0xE0 0x71 is delete, while 0x71 alone produces nothing. 0xE0 0x14 is the right control key.
- R11: A byte strobe that arrives while a previous byte is still being processed is ignored, and the first byte's result is published unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| byte_vld | input | 1 | One-cycle strobe: a received scan byte is present |
| byte_in | input | 8 | Received scan byte |
| ascii_code | output | 7 | Last published ASCII value |
| ascii_new | output | 1 | High while `ascii_code` holds a freshly published value |

## Verification
The stimulus covers four groups of key presses. Plain letters with no modifier active check the base lookup. Letters, digits and punctuation are each pressed under shift, under caps lock, and under both. This separates the letter-only caps rule from the shift rule, which covers every character key. The same keys pressed under left and under right control, with shift and caps lock also active, show that control takes precedence. Fixed keys, extended keys, unknown keys and release sequences show that output appears only for presses that have a character meaning. A strobe injected while a byte is still being processed shows that the sequencer ignores it.

// File: rtl/kbd_xlat_pkg.sv
package kbd_xlat_pkg;
    parameter int SCAN_W = 8;
    parameter int CHAR_W = 7;

    localparam logic [SCAN_W-1:0] SC_EXT    = 8'hE0;
    localparam logic [SCAN_W-1:0] SC_REL    = 8'hF0;
    localparam logic [SCAN_W-1:0] SC_LSHIFT = 8'h12;
    localparam logic [SCAN_W-1:0] SC_RSHIFT = 8'h59;
    localparam logic [SCAN_W-1:0] SC_CTRL   = 8'h14;
    localparam logic [SCAN_W-1:0] SC_CAPS   = 8'h58;

    typedef enum logic [1:0] {
        ST_READY, ST_NEW_CODE, ST_TRANSLATE, ST_OUTPUT
    } seq_state_e;

    typedef struct packed {
        logic              hit;
        logic              fixed;
        logic              letter;
        logic [CHAR_W-1:0] base;
        logic [CHAR_W-1:0] upper;
    } key_info_t;

    typedef struct packed {
        seq_state_e        st;
        logic [SCAN_W-1:0] code;
        logic              ext;
        logic              rel;
        logic              sh_l;
        logic              sh_r;
        logic              ctl_l;
        logic              ctl_r;
        logic              caps;
        logic [CHAR_W-1:0] ascii;
        logic              fresh;
    } seq_regs_t;
endpackage

// File: rtl/kbd_key_map.sv
module kbd_key_map
    import kbd_xlat_pkg::*;
(
    input  logic              ext,
    input  logic [SCAN_W-1:0] code,
    output key_info_t         info
);
    localparam int KEY_W = SCAN_W + 1;

    function automatic key_info_t mk(input logic [CHAR_W-1:0] b,
                                     input logic [CHAR_W-1:0] u,
                                     input logic l, input logic f);
        key_info_t k;
        k.hit = 1'b1; k.fixed = f; k.letter = l; k.base = b; k.upper = u;
        return k;
    endfunction

    function automatic key_info_t lt(input logic [CHAR_W-1:0] b);
        return mk(b, b ^ 7'h20, 1'b1, 1'b0);
    endfunction

    function automatic key_info_t sy(input logic [CHAR_W-1:0] b,
                                     input logic [CHAR_W-1:0] u);
        return mk(b, u, 1'b0, 1'b0);
    endfunction

    function automatic key_info_t fx(input logic [CHAR_W-1:0] b);
        return mk(b, b, 1'b0, 1'b1);
    endfunction

    logic [KEY_W-1:0] key;
    assign key = {ext, code};

    always_comb begin
        info = '0;
        case (key)
            9'h01C: info = lt(7'h61); 9'h032: info = lt(7'h62);
            9'h021: info = lt(7'h63); 9'h023: info = lt(7'h64);
            9'h024: info = lt(7'h65); 9'h02B: info = lt(7'h66);
            9'h034: info = lt(7'h67); 9'h033: info = lt(7'h68);
            9'h043: info = lt(7'h69); 9'h03B: info = lt(7'h6A);
            9'h042: info = lt(7'h6B); 9'h04B: info = lt(7'h6C);
            9'h03A: info = lt(7'h6D); 9'h031: info = lt(7'h6E);
            9'h044: info = lt(7'h6F); 9'h04D: info = lt(7'h70);
            9'h015: info = lt(7'h71); 9'h02D: info = lt(7'h72);
            9'h01B: info = lt(7'h73); 9'h02C: info = lt(7'h74);
            9'h03C: info = lt(7'h75); 9'h02A: info = lt(7'h76);
            9'h01D: info = lt(7'h77); 9'h022: info = lt(7'h78);
            9'h035: info = lt(7'h79); 9'h01A: info = lt(7'h7A);
            9'h016: info = sy(7'h31, 7'h21); 9'h01E: info = sy(7'h32, 7'h40);
            9'h026: info = sy(7'h33, 7'h23); 9'h025: info = sy(7'h34, 7'h24);
            9'h02E: info = sy(7'h35, 7'h25); 9'h036: info = sy(7'h36, 7'h5E);
            9'h03D: info = sy(7'h37, 7'h26); 9'h03E: info = sy(7'h38, 7'h2A);
            9'h046: info = sy(7'h39, 7'h28); 9'h045: info = sy(7'h30, 7'h29);
            9'h00E: info = sy(7'h60, 7'h7E); 9'h04E: info = sy(7'h2D, 7'h5F);
            9'h055: info = sy(7'h3D, 7'h2B); 9'h054: info = sy(7'h5B, 7'h7B);
            9'h05B: info = sy(7'h5D, 7'h7D); 9'h05D: info = sy(7'h5C, 7'h7C);
            9'h04C: info = sy(7'h3B, 7'h3A); 9'h052: info = sy(7'h27, 7'h22);
            9'h041: info = sy(7'h2C, 7'h3C); 9'h049: info = sy(7'h2E, 7'h3E);
            9'h04A: info = sy(7'h2F, 7'h3F); 9'h029: info = sy(7'h20, 7'h20);
            9'h066: info = fx(7'h08); 9'h00D: info = fx(7'h09);
            9'h05A: info = fx(7'h0D); 9'h076: info = fx(7'h1B);
            9'h171: info = fx(7'h7F);
            default: info = '0;
        endcase
    end
endmodule

// File: rtl/kbd_char_sel.sv
module kbd_char_sel
    import kbd_xlat_pkg::*;
(
    input  key_info_t         info,
    input  logic              shift,
    input  logic              ctrl,
    input  logic              caps,
    output logic              emit,
    output logic [CHAR_W-1:0] char_out
);
    localparam int LOW_W = CHAR_W - 2;

    logic [CHAR_W-1:0] ctl_src;

    always_comb begin
        emit     = 1'b0;
        char_out = '0;
        ctl_src  = info.letter ? info.upper : info.base;
        if (info.hit) begin
            if (info.fixed) begin
                emit     = 1'b1;
                char_out = info.base;
            end else if (ctrl) begin
                if (ctl_src[CHAR_W-1 -: 2] == 2'b10) begin
                    emit     = 1'b1;
                    char_out = {2'b00, ctl_src[LOW_W-1:0]};
                end else if (info.upper[CHAR_W-1 -: 2] == 2'b10) begin
                    emit     = 1'b1;
                    char_out = {2'b00, info.upper[LOW_W-1:0]};
                end
            end else if (info.letter) begin
                emit     = 1'b1;
                char_out = (shift ^ caps) ? info.upper : info.base;
            end else begin
                emit     = 1'b1;
                char_out = shift ? info.upper : info.base;
            end
        end
    end
endmodule

// File: rtl/kbd_seq.sv
module kbd_seq
    import kbd_xlat_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              byte_vld,
    input  logic [SCAN_W-1:0] byte_in,
    input  logic              emit,
    input  logic [CHAR_W-1:0] char_in,
    output logic              look_ext,
    output logic [SCAN_W-1:0] look_code,
    output logic              shift,
    output logic              ctrl,
    output logic              caps,
    output logic [CHAR_W-1:0] ascii_code,
    output logic              ascii_new
);
    seq_regs_t q, d;

    always_comb begin
        d = q;
        case (q.st)
            ST_READY: begin
                if (byte_vld) begin
                    d.code  = byte_in;
                    d.fresh = 1'b0;
                    d.st    = ST_NEW_CODE;
                end
            end
            ST_NEW_CODE: begin
                if (q.code == SC_EXT) begin
                    d.ext = 1'b1;
                    d.st  = ST_READY;
                end else if (q.code == SC_REL) begin
                    d.rel = 1'b1;
                    d.st  = ST_READY;
                end else begin
                    d.st  = ST_TRANSLATE;
                end
            end
            ST_TRANSLATE: begin
                if (!q.ext && q.code == SC_LSHIFT) d.sh_l = !q.rel;
                if (!q.ext && q.code == SC_RSHIFT) d.sh_r = !q.rel;
                if (q.code == SC_CTRL) begin
                    if (q.ext) d.ctl_r = !q.rel;
                    else       d.ctl_l = !q.rel;
                end
                if (!q.ext && !q.rel && q.code == SC_CAPS) d.caps = !q.caps;
                if (emit && !q.rel) begin
                    d.ascii = char_in;
                    d.st    = ST_OUTPUT;
                end else begin
                    d.st    = ST_READY;
                end
                d.ext = 1'b0;
                d.rel = 1'b0;
            end
            ST_OUTPUT: begin
                d.fresh = 1'b1;
                d.st    = ST_READY;
            end
            default: d.st = ST_READY;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign look_ext   = q.ext;
    assign look_code  = q.code;
    assign shift      = q.sh_l | q.sh_r;
    assign ctrl       = q.ctl_l | q.ctl_r;
    assign caps       = q.caps;
    assign ascii_code = q.ascii;
    assign ascii_new  = q.fresh;

    // R3
    flag_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_READY && byte_vld) |=> !ascii_new);

    // R2
    publish_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_OUTPUT) |=> (ascii_new && q.st == ST_READY));

    // R2
    code_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ascii_new && $past(ascii_new)) |-> $stable(ascii_code));

    // R4
    release_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_TRANSLATE && q.rel) |=> (q.st == ST_READY && !ascii_new));

    // R11
    busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st != ST_READY && q.st != ST_OUTPUT) |=> $stable(q.code));

    // R10
    prefix_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_NEW_CODE && q.code == SC_EXT) |=> (q.ext && q.st == ST_READY));
endmodule

// File: rtl/kbd_ascii_xlat.sv
module kbd_ascii_xlat
    import kbd_xlat_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              byte_vld,
    input  logic [SCAN_W-1:0] byte_in,
    output logic [CHAR_W-1:0] ascii_code,
    output logic              ascii_new
);
    logic              look_ext;
    logic [SCAN_W-1:0] look_code;
    logic              shift, ctrl, caps, emit;
    logic [CHAR_W-1:0] char_sel;
    key_info_t         info;

    kbd_seq u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .byte_vld   (byte_vld),
        .byte_in    (byte_in),
        .emit       (emit),
        .char_in    (char_sel),
        .look_ext   (look_ext),
        .look_code  (look_code),
        .shift      (shift),
        .ctrl       (ctrl),
        .caps       (caps),
        .ascii_code (ascii_code),
        .ascii_new  (ascii_new)
    );

    kbd_key_map u_map (
        .ext  (look_ext),
        .code (look_code),
        .info (info)
    );

    kbd_char_sel u_sel (
        .info     (info),
        .shift    (shift),
        .ctrl     (ctrl),
        .caps     (caps),
        .emit     (emit),
        .char_out (char_sel)
    );
endmodule

// File: tb/tb_kbd_ascii_xlat.sv
module tb_kbd_ascii_xlat;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       byte_vld = 1'b0;
    logic [7:0] byte_in = 8'h00;
    logic [6:0] ascii_code;
    logic       ascii_new;

    int    checks = 0;
    int    failures = 0;
    bit    comparing = 1'b0;
    string cur_req = "R1";

    bit m_sh_l, m_sh_r, m_ctl_l, m_ctl_r, m_caps, m_ext, m_rel;
    bit exp_new = 1'b0;
    int exp_code = 0;

    always #5 clk = ~clk;

    kbd_ascii_xlat dut (
        .clk(clk), .rst_n(rst_n), .byte_vld(byte_vld), .byte_in(byte_in),
        .ascii_code(ascii_code), .ascii_new(ascii_new)
    );

    function automatic int ref_char(bit ext, byte c, bit sh, bit ct, bit cp);
        byte lc[26] = '{8'h1C, 8'h32, 8'h21, 8'h23, 8'h24, 8'h2B, 8'h34, 8'h33,
                        8'h43, 8'h3B, 8'h42, 8'h4B, 8'h3A, 8'h31, 8'h44, 8'h4D,
                        8'h15, 8'h2D, 8'h1B, 8'h2C, 8'h3C, 8'h2A, 8'h1D, 8'h22,
                        8'h35, 8'h1A};
        byte lo, hi;
        if (ext) return (c == 8'h71) ? 127 : -1;
        case (c)
            8'h66: return 8;
            8'h0D: return 9;
            8'h5A: return 13;
            8'h76: return 27;
            default: ;
        endcase
        for (int i = 0; i < 26; i++)
            if (lc[i] == c) begin
                if (ct) return i + 1;
                return (sh ^ cp) ? 65 + i : 97 + i;
            end
        case (c)
            8'h16: begin lo = "1"; hi = "!"; end
            8'h1E: begin lo = "2"; hi = "@"; end
            8'h36: begin lo = "6"; hi = "^"; end
            8'h4E: begin lo = "-"; hi = "_"; end
            8'h54: begin lo = "["; hi = "{"; end
            8'h5D: begin lo = "\\"; hi = "|"; end
            8'h4C: begin lo = ";"; hi = ":"; end
            8'h52: begin lo = "'"; hi = "\""; end
            8'h4A: begin lo = "/"; hi = "?"; end
            8'h29: begin lo = " "; hi = " "; end
            default: return -1;
        endcase
        if (ct) begin
            if (lo >= 64 && lo < 96) return lo - 64;
            if (hi >= 64 && hi < 96) return hi - 64;
            return -1;
        end
        return sh ? hi : lo;
    endfunction

    always @(negedge clk) begin
        if (comparing) begin
            checks++;
            if (ascii_new !== exp_new) begin
                failures++;
                $display("FAIL %s ascii_new actual=%0b expected=%0b", cur_req, ascii_new, exp_new);
            end else if (exp_new && ascii_code !== exp_code[6:0]) begin
                failures++;
                $display("FAIL %s ascii_code actual=%02h expected=%02h", cur_req, ascii_code, exp_code[6:0]);
            end
        end
    end

    task automatic send(input byte b, input bit busy_inject = 1'b0, input byte b2 = 8'h00);
        int out = -1;
        @(negedge clk);
        byte_vld = 1'b1;
        byte_in  = b;
        @(posedge clk); #1;
        if (busy_inject) byte_in = b2;
        else byte_vld = 1'b0;
        exp_new = 1'b0;
        if (b == 8'hE0) m_ext = 1'b1;
        else if (b == 8'hF0) m_rel = 1'b1;
        else begin
            if (!m_ext && b == 8'h12) m_sh_l = !m_rel;
            else if (!m_ext && b == 8'h59) m_sh_r = !m_rel;
            else if (b == 8'h14) begin
                if (m_ext) m_ctl_r = !m_rel; else m_ctl_l = !m_rel;
            end else if (!m_ext && b == 8'h58) begin
                if (!m_rel) m_caps = !m_caps;
            end else if (!m_rel)
                out = ref_char(m_ext, b, m_sh_l | m_sh_r, m_ctl_l | m_ctl_r, m_caps);
            m_ext = 1'b0;
            m_rel = 1'b0;
        end
        @(posedge clk); #1;
        byte_vld = 1'b0;
        @(posedge clk); #1;
        if (out >= 0) exp_code = out;
        @(posedge clk); #1;
        if (out >= 0) exp_new = 1'b1;
        repeat (4) @(posedge clk);
    endtask

    initial begin
        #2_000_000;
        failures++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        checks++;
        if (ascii_new !== 1'b0 || ascii_code !== 7'h00) begin
            failures++;
            $display("FAIL R1 reset actual=%0b/%02h expected=0/00", ascii_new, ascii_code);
        end
        comparing = 1'b1;

        cur_req = "R2";
        send(8'h1C); send(8'h1A); send(8'h15);
        cur_req = "R3";
        send(8'hE0); send(8'h71); send(8'hF0); send(8'h1C);
        cur_req = "R4";
        send(8'h1C); send(8'hF0); send(8'h1C); send(8'hE0); send(8'hF0); send(8'h71);
        cur_req = "R5";
        send(8'h12); send(8'h1C); send(8'h16); send(8'h4E); send(8'hF0); send(8'h12);
        send(8'h1C); send(8'h59); send(8'h52); send(8'h5D); send(8'hF0); send(8'h59); send(8'h52);
        cur_req = "R6";
        send(8'h58); send(8'hF0); send(8'h58); send(8'h1C); send(8'h16);
        send(8'h12); send(8'h1C); send(8'h16); send(8'hF0); send(8'h12);
        send(8'h58); send(8'hF0); send(8'h58); send(8'h1C);
        cur_req = "R7";
        send(8'h14); send(8'h1C); send(8'h54); send(8'h1E); send(8'h4E); send(8'h36);
        send(8'h12); send(8'h1A); send(8'hF0); send(8'h12);
        send(8'h58); send(8'h1C); send(8'h58);
        send(8'h4C); send(8'h29); send(8'hF0); send(8'h14); send(8'h1C);
        send(8'hE0); send(8'h14); send(8'h32); send(8'hE0); send(8'hF0); send(8'h14); send(8'h32);
        cur_req = "R8";
        send(8'h66); send(8'h0D); send(8'h5A); send(8'h76); send(8'hE0); send(8'h71);
        send(8'h12); send(8'h14); send(8'h5A); send(8'h66); send(8'hF0); send(8'h14);
        send(8'hF0); send(8'h12);
        cur_req = "R9";
        send(8'h1C); send(8'h05); send(8'h71); send(8'hE0); send(8'h5A); send(8'h12);
        send(8'hF0); send(8'h12);
        cur_req = "R10";
        send(8'h71); send(8'hE0); send(8'h71); send(8'hE0); send(8'h14); send(8'h15);
        send(8'hE0); send(8'hF0); send(8'h14); send(8'h15);
        cur_req = "R11";
        send(8'h1C, 1'b1, 8'h1A); send(8'h4A, 1'b1, 8'h66); send(8'h32);

        comparing = 1'b0;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule